// File: doc/BRIEF.md
# Eight-Point Modular Number Theoretic Transform Engine

This block computes an exact eight-point transform over the residues modulo the prime 337. It uses 85 as the primitive 8th root of unity. A caller places eight residues on a flat input vector, chooses forward or inverse with a direction bit and pulses start. The engine copies the operands, then forms each output as a modular sum of products of the inputs and powers of the root. A single-cycle done pulse announces the eight results. There is no rounding and no complex arithmetic. Every value is an unsigned residue.

The datapath has one multiplier. Each step adds one product to the running sum and reduces the sum modulo 337. The inverse direction uses the negated exponent, which is the same as using the inverse root 226. It ends with an extra pass that multiplies each element by 295, the inverse of 8. The control is one enumerated state machine:

- ST_IDLE waits for start and moves to ST_ACCUM when start is seen.
- ST_ACCUM runs 64 steps, one product per clock, with an inner index over the inputs and an outer index over the outputs. After its last step it moves to ST_SCALE for an inverse transform, or to ST_COMMIT for a forward transform.
- ST_SCALE runs 8 steps, one element per clock, and then moves to ST_COMMIT.
- ST_COMMIT publishes the results and always returns to ST_IDLE.

Top module: `ntt8_engine`

## Requirements
- R1: While reset is asserted and after it is released, done_o is 0 and every bit of result_o is 0 until the first transform completes.
- R2: With inverse_i = 0, the result element k equals the sum over j of x[j]·85^(j·k mod 8), taken mod 337. Element i of data_i and of result_o occupies bits [9i+8:9i].
- R3: With inverse_i = 1, the result element k equals 295 · (the sum over j of X[j]·226^(j·k mod 8)), taken mod 337.
- R4: For any input vector with all elements in 0..336, running the inverse transform on the output of the forward transform returns the original vector.
- R5: done_o is high for exactly one cycle. It rises 65 clock edges after the edge that accepted start for a forward transform, and 73 edges after it for an inverse transform.
- R6: result_o changes only in the cycle in which done_o is high, and holds its value at all other times.
- R7: A start pulse that arrives while a transform is in progress, including the cycle of the commit state, is ignored. It does not change the running result and it produces no extra done pulse.
- R8: data_i and inverse_i are sampled only on the edge that accepts start. Later changes have no effect on the running transform.
- R9: Every element of result_o is in the range 0..336 when done_o is high.
- R10: A start asserted in the cycle in which done_o is high is accepted, so jobs can run back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a transform when the engine is idle |
| inverse_i | input | 1 | 0 selects the forward transform, 1 selects the inverse |
| data_i | input | 72 | Eight 9-bit residues; element i is at bits [9i+8:9i] |
| result_o | output | 72 | Eight 9-bit result residues, same element layout |
| done_o | output | 1 | One-cycle pulse when result_o is updated |

## Verification
Each output is a sum over all eight inputs, so a wrong index counter, a wrong twiddle exponent or a bad partial sum in the accumulator changes at least one element of result_o. That error appears on the first done pulse after it occurs. A stuck or skipped state in ST_ACCUM or ST_SCALE shifts the done pulse away from edge 65 or 73 and is caught within that one job. A missing scale pass on an inverse transform breaks the forward-then-inverse round trip at once. A bench model that tracks the expected done and result on every clock catches any early, late or stray publish in the cycle in which it happens.

// File: rtl/ntt8_pkg.sv
package ntt8_pkg;

    localparam int NTT_N      = 8;
    localparam int NTT_DATA_W = 9;
    localparam int NTT_MOD    = 337;
    localparam int NTT_ROOT   = 85;
    localparam int NTT_INV_N  = 295;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCUM,
        ST_SCALE,
        ST_COMMIT
    } ntt_state_e;

    // base^e mod m by repeated multiplication (elaboration-time constant use)
    function automatic int pow_mod(input int base, input int e, input int m);
        int r;
        r = 1;
        for (int i = 0; i < e; i++) begin
            r = (r * base) % m;
        end
        return r;
    endfunction

endpackage

// File: rtl/ntt8_modred.sv
// Reduces an unsigned value modulo a constant with a ladder of
// conditional subtractions of the modulus shifted left.
module ntt8_modred #(
    parameter int IN_W    = 19,
    parameter int DATA_W  = 9,
    parameter int MODULUS = 337
) (
    input  logic [IN_W-1:0]   val_i,
    output logic [DATA_W-1:0] res_o
);

    localparam int STAGES = IN_W - DATA_W + 2;
    localparam int CW     = IN_W + 1;

    logic [CW-1:0] chain [STAGES];

    assign chain[0] = CW'(val_i);

    // After the stage with shift s, the value is below MODULUS << s.
    for (genvar i = 0; i < STAGES - 1; i++) begin : g_stage
        localparam logic [CW-1:0] SUB = CW'(MODULUS) << (STAGES - 1 - i);
        assign chain[i+1] = (chain[i] >= SUB) ? (chain[i] - SUB) : chain[i];
    end

    assign res_o = DATA_W'((chain[STAGES-1] >= CW'(MODULUS))
                           ? (chain[STAGES-1] - CW'(MODULUS))
                           : chain[STAGES-1]);

endmodule

// File: rtl/ntt8_mac.sv
// One modular multiply-accumulate step: (acc + a*b) mod MODULUS.
module ntt8_mac #(
    parameter int DATA_W  = 9,
    parameter int MODULUS = 337
) (
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o
);

    localparam int ACC_W = 2 * DATA_W + 1;

    logic [ACC_W-1:0] sum;

    assign sum = ACC_W'(acc_i) + (ACC_W'(a_i) * ACC_W'(b_i));

    ntt8_modred #(
        .IN_W   (ACC_W),
        .DATA_W (DATA_W),
        .MODULUS(MODULUS)
    ) u_red (
        .val_i(sum),
        .res_o(res_o)
    );

endmodule

// File: rtl/ntt8_twiddle.sv
// Constant table of ROOT^e mod MODULUS for e = 0 .. N_PTS-1.
module ntt8_twiddle #(
    parameter int N_PTS   = 8,
    parameter int DATA_W  = 9,
    parameter int MODULUS = 337,
    parameter int ROOT    = 85,
    localparam int LOG_N  = $clog2(N_PTS)
) (
    input  logic [LOG_N-1:0]  exp_i,
    output logic [DATA_W-1:0] pow_o
);

    logic [DATA_W-1:0] tbl [N_PTS];

    for (genvar g = 0; g < N_PTS; g++) begin : g_pow
        localparam int PV = ntt8_pkg::pow_mod(ROOT, g, MODULUS);
        assign tbl[g] = DATA_W'(PV);
    end

    assign pow_o = tbl[exp_i];

endmodule

// File: rtl/ntt8_engine.sv
module ntt8_engine
    import ntt8_pkg::*;
#(
    parameter int N_PTS   = NTT_N,
    parameter int DATA_W  = NTT_DATA_W,
    parameter int MODULUS = NTT_MOD,
    parameter int ROOT    = NTT_ROOT,
    parameter int INV_N   = NTT_INV_N
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      inverse_i,
    input  logic [N_PTS*DATA_W-1:0]   data_i,
    output logic [N_PTS*DATA_W-1:0]   result_o,
    output logic                      done_o
);

    localparam int LOG_N = $clog2(N_PTS);
    localparam logic [LOG_N-1:0] IDX_LAST = LOG_N'(N_PTS - 1);

    ntt_state_e        state, state_nx;

    logic [DATA_W-1:0] x_buf    [N_PTS];
    logic [DATA_W-1:0] work     [N_PTS];
    logic [DATA_W-1:0] result_q [N_PTS];
    logic [DATA_W-1:0] acc;
    logic [LOG_N-1:0]  j_idx, k_idx;
    logic              inv_q;
    logic              done_q;

    logic [LOG_N-1:0]  exp_fwd, exp_sel;
    logic [DATA_W-1:0] twiddle;
    logic [DATA_W-1:0] mac_acc, mac_a, mac_b, mac_res;
    logic              last_j, last_k;

    assign last_j = (j_idx == IDX_LAST);
    assign last_k = (k_idx == IDX_LAST);

    // exponent j*k mod N (N is a power of two); negated for the inverse
    assign exp_fwd = j_idx * k_idx;
    assign exp_sel = inv_q ? (LOG_N'(0) - exp_fwd) : exp_fwd;

    ntt8_twiddle #(
        .N_PTS  (N_PTS),
        .DATA_W (DATA_W),
        .MODULUS(MODULUS),
        .ROOT   (ROOT)
    ) u_twiddle (
        .exp_i(exp_sel),
        .pow_o(twiddle)
    );

    // operand selection for the shared multiply-accumulate unit
    always_comb begin
        if (state == ST_SCALE) begin
            mac_acc = '0;
            mac_a   = work[k_idx];
            mac_b   = DATA_W'(INV_N);
        end else begin
            mac_acc = (j_idx == '0) ? '0 : acc;
            mac_a   = x_buf[j_idx];
            mac_b   = twiddle;
        end
    end

    ntt8_mac #(
        .DATA_W (DATA_W),
        .MODULUS(MODULUS)
    ) u_mac (
        .acc_i(mac_acc),
        .a_i  (mac_a),
        .b_i  (mac_b),
        .res_o(mac_res)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start_i) begin
                    state_nx = ST_ACCUM;
                end
            end
            ST_ACCUM: begin
                if (last_j && last_k) begin
                    state_nx = inv_q ? ST_SCALE : ST_COMMIT;
                end
            end
            ST_SCALE: begin
                if (last_k) begin
                    state_nx = ST_COMMIT;
                end
            end
            ST_COMMIT: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

    // working datapath: operand capture, indices, accumulator, work buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_PTS; i++) begin
                x_buf[i] <= '0;
                work[i]  <= '0;
            end
            acc   <= '0;
            j_idx <= '0;
            k_idx <= '0;
            inv_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        for (int i = 0; i < N_PTS; i++) begin
                            x_buf[i] <= data_i[i*DATA_W +: DATA_W];
                        end
                        inv_q <= inverse_i;
                        acc   <= '0;
                        j_idx <= '0;
                        k_idx <= '0;
                    end
                end
                ST_ACCUM: begin
                    if (last_j) begin
                        work[k_idx] <= mac_res;
                        j_idx       <= '0;
                        k_idx       <= k_idx + 1'b1;
                    end else begin
                        acc   <= mac_res;
                        j_idx <= j_idx + 1'b1;
                    end
                end
                ST_SCALE: begin
                    work[k_idx] <= mac_res;
                    k_idx       <= k_idx + 1'b1;
                end
                ST_COMMIT: begin
                end
            endcase
        end
    end

    // outputs: published results and done pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            for (int i = 0; i < N_PTS; i++) begin
                result_q[i] <= '0;
            end
        end else begin
            done_q <= (state == ST_COMMIT);
            if (state == ST_COMMIT) begin
                for (int i = 0; i < N_PTS; i++) begin
                    result_q[i] <= work[i];
                end
            end
        end
    end

    assign done_o = done_q;

    for (genvar g = 0; g < N_PTS; g++) begin : g_out
        assign result_o[g*DATA_W +: DATA_W] = result_q[g];
    end

endmodule

// File: rtl/ntt8_engine_chk.sv
module ntt8_engine_chk #(
    parameter int N_PTS   = 8,
    parameter int DATA_W  = 9,
    parameter int MODULUS = 337
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start_i,
    input logic                    inverse_i,
    input logic [N_PTS*DATA_W-1:0] result_o,
    input logic                    done_o
);

    localparam int LAT_FWD = N_PTS * N_PTS + 1;
    localparam int LAT_INV = N_PTS * N_PTS + N_PTS + 1;

    logic        busy_c;
    logic        dir_c;
    logic [15:0] cnt;

    // independent job tracker built from the ports only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_c <= 1'b0;
            dir_c  <= 1'b0;
            cnt    <= '0;
        end else if (start_i && (!busy_c || done_o)) begin
            busy_c <= 1'b1;
            dir_c  <= inverse_i;
            cnt    <= '0;
        end else if (done_o) begin
            busy_c <= 1'b0;
        end else if (busy_c) begin
            cnt <= cnt + 16'd1;
        end
    end

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_c && (int'(cnt) == (dir_c ? LAT_INV : LAT_FWD))));

    // R5
    job_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_c |-> (int'(cnt) <= (dir_c ? LAT_INV : LAT_FWD)));

    // R7
    no_stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_c |-> !done_o);

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    for (genvar g = 0; g < N_PTS; g++) begin : g_range
        // R9
        residue_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            done_o |-> (int'(result_o[g*DATA_W +: DATA_W]) < MODULUS));
    end

endmodule

bind ntt8_engine ntt8_engine_chk #(
    .N_PTS  (N_PTS),
    .DATA_W (DATA_W),
    .MODULUS(MODULUS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .inverse_i(inverse_i),
    .result_o (result_o),
    .done_o   (done_o)
);

// File: tb/ntt8_engine_test.sv
module ntt8_engine_test;

    localparam int CLK_PERIOD = 10;
    localparam int N    = 8;
    localparam int DW   = 9;
    localparam int VW   = N * DW;
    localparam int MODV = 337;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          inverse_i = 1'b0;
    logic [VW-1:0] data_i = '0;
    logic [VW-1:0] result_o;
    logic          done_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit run_live = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ntt8_engine uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .inverse_i(inverse_i),
        .data_i   (data_i),
        .result_o (result_o),
        .done_o   (done_o)
    );

    function automatic int powm(input int b, input int e);
        int r = 1;
        for (int i = 0; i < e; i++) r = (r * b) % MODV;
        return r;
    endfunction

    // direct O(n^2) evaluation of R2 / R3
    function automatic logic [VW-1:0] ref_ntt(input logic [VW-1:0] v, input bit inv);
        logic [VW-1:0] o = '0;
        for (int k = 0; k < N; k++) begin
            int s = 0;
            for (int j = 0; j < N; j++) begin
                s = (s + int'(v[j*DW +: DW]) * powm(inv ? 226 : 85, (j * k) % N)) % MODV;
            end
            if (inv) s = (s * 295) % MODV;
            o[k*DW +: DW] = DW'(s);
        end
        return o;
    endfunction

    function automatic logic [VW-1:0] fill(input int a0, input int rest);
        logic [VW-1:0] o = '0;
        for (int i = 0; i < N; i++) o[i*DW +: DW] = DW'((i == 0) ? a0 : rest);
        return o;
    endfunction

    function automatic logic [VW-1:0] rand_vec();
        logic [VW-1:0] o = '0;
        for (int i = 0; i < N; i++) o[i*DW +: DW] = DW'($urandom % MODV);
        return o;
    endfunction

    // ---------------- cycle-level behavioural model ----------------
    logic          m_busy, m_inv, m_job_inv, exp_done;
    int            m_cnt, m_lat;
    logic [VW-1:0] m_pend, exp_res;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy <= 1'b0; m_inv <= 1'b0; m_job_inv <= 1'b0; exp_done <= 1'b0;
            m_cnt <= 0; m_lat <= 0; m_pend <= '0; exp_res <= '0;
        end else begin
            exp_done <= 1'b0;
            if (m_busy) begin
                m_cnt <= m_cnt + 1;
                if (m_cnt + 1 == m_lat) begin
                    exp_done  <= 1'b1;
                    exp_res   <= m_pend;
                    m_job_inv <= m_inv;
                    m_busy    <= 1'b0;
                end
            end else if (start_i) begin
                m_busy <= 1'b1;
                m_cnt  <= 0;
                m_lat  <= inverse_i ? 73 : 65;
                m_inv  <= inverse_i;
                m_pend <= ref_ntt(data_i, inverse_i);
            end
        end
    end

    // per-clock comparison (R5, R6, R7, R8, R2, R3)
    always @(negedge clk) begin
        if (run_live) begin
            n_cmp++;
            if (done_o !== exp_done) begin
                n_bad++;
                $display("FAIL R5 per-cycle done: actual=%0b expected=%0b", done_o, exp_done);
            end
            n_cmp++;
            if (result_o !== exp_res) begin
                n_bad++;
                $display("FAIL %s per-cycle result: actual=%h expected=%h",
                         m_job_inv ? "R3" : "R2", result_o, exp_res);
            end
        end
    end

    task automatic check_vec(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic launch(input logic [VW-1:0] v, input bit inv);
        start_i   = 1'b1;
        data_i    = v;
        inverse_i = inv;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(output logic [VW-1:0] r, output int cyc);
        cyc = 1;
        while (!done_o) begin
            @(negedge clk);
            cyc++;
        end
        r = result_o;
        for (int i = 0; i < N; i++) begin
            n_cmp++;
            if (int'(r[i*DW +: DW]) >= MODV) begin
                n_bad++;
                $display("FAIL R9 element %0d: actual=%0d expected=<%0d", i, r[i*DW +: DW], MODV);
            end
        end
    endtask

    // launches, waits, checks the latency (R5) and returns at the done cycle
    task automatic run_job(input logic [VW-1:0] v, input bit inv, output logic [VW-1:0] r);
        int cyc;
        launch(v, inv);
        wait_done(r, cyc);
        n_cmp++;
        if (cyc != (inv ? 74 : 66)) begin
            n_bad++;
            $display("FAIL R5 latency: actual=%0d expected=%0d", cyc, inv ? 74 : 66);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R5 watchdog: actual=no completion expected=completion");
        summary();
        $finish;
    end

    initial begin
        logic [VW-1:0] r, r2, va, vb;
        int cyc;

        repeat (3) @(negedge clk);
        // R1 during reset
        check_vec("R1", {done_o, result_o}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 after release
        check_vec("R1", {done_o, result_o}, '0);
        run_live = 1'b1;
        @(negedge clk);

        // R2: impulse gives all ones
        run_job(fill(1, 0), 1'b0, r);
        check_vec("R2", r, fill(1, 1));
        @(negedge clk);

        // R2: constant 5 gives 40 in bin 0
        run_job(fill(5, 5), 1'b0, r);
        check_vec("R2", r, fill(40, 0));
        @(negedge clk);

        // R2: all 336 gives 329 in bin 0
        run_job(fill(336, 336), 1'b0, r);
        check_vec("R2", r, fill(329, 0));

        // R3: inverse impulse gives 295 everywhere (R10: started on the done cycle)
        run_job(fill(1, 0), 1'b1, r);
        check_vec("R3", r, fill(295, 295));

        // R4 and R10: forward then immediate inverse returns the input
        for (int t = 0; t < 4; t++) begin
            va = rand_vec();
            run_job(va, 1'b0, r);
            check_vec("R2", r, ref_ntt(va, 1'b0));
            run_job(r, 1'b1, r2);
            check_vec("R4", r2, va);
        end
        va = fill(336, 336);
        va[3*DW +: DW] = 9'd0;
        run_job(va, 1'b0, r);
        run_job(r, 1'b1, r2);
        check_vec("R4", r2, va);

        // R3: random inverse transforms
        for (int t = 0; t < 3; t++) begin
            va = rand_vec();
            run_job(va, 1'b1, r);
            check_vec("R3", r, ref_ntt(va, 1'b1));
        end
        @(negedge clk);

        // R7: start pulse with other data and direction during a running job
        va = rand_vec();
        vb = rand_vec();
        launch(va, 1'b0);
        repeat (10) @(negedge clk);
        launch(vb, 1'b1);
        wait_done(r, cyc);
        check_vec("R7", r, ref_ntt(va, 1'b0));
        @(negedge clk);
        n_cmp++;
        if (done_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R7 extra done: actual=%0b expected=0", done_o);
        end

        // R8: inputs change without start while a job runs
        va = rand_vec();
        launch(va, 1'b1);
        repeat (5) @(negedge clk);
        data_i    = rand_vec();
        inverse_i = 1'b0;
        wait_done(r, cyc);
        check_vec("R8", r, ref_ntt(va, 1'b1));

        // R6: result holds while idle with changing inputs
        r2 = result_o;
        for (int t = 0; t < 5; t++) begin
            @(negedge clk);
            data_i = rand_vec();
        end
        check_vec("R6", result_o, r2);

        repeat (3) @(negedge clk);
        run_live = 1'b0;
        summary();
        $finish;
    end

endmodule